// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block holds the small control and status registers that sit beside the I/O logic of a workstation. It has three plain 8-bit bytes: configuration, diagnostic and modem control. It also has a misc-functions byte, a power-down control byte, a 16-bit LED word and a 32-bit system-control word. Software reaches them through a synchronous register port. The port has a register select, a write strobe, write data and a combinational read bus.

The block turns register writes into side effects:
- a one-cycle pulse that ends a floppy transfer;
- a one-cycle power-off request;
- a one-cycle system-reset request.

The power-down byte keeps a sticky power-fail flag. The flag follows a synchronized power-failing input, and together with an enable bit in the configuration byte it drives a level interrupt. A chip reset clears the operational bytes. It leaves the diagnostic byte and the system-control word untouched, so that software can still read the cause of a reset after it happens.

Top module: `auxc_bank`

## Requirements
- R1: `pf_irq` is high exactly when power-down bit 5 (power fail) and configuration bit 3 (power interrupt enable) are both set. A configuration write takes effect on `pf_irq` in the cycle after the write strobe.
- R2: Each time the synchronized `pwr_failing` input changes, power-down bit 5 is set if the input is now high and configuration bit 3 is set; otherwise it is cleared. Between changes the bit is sticky.
- R3: A write to the power-down byte takes only bits 0 (power off) and 1 (interrupt clear) from the write data and keeps the stored bit 5. All other bits read as zero.
- R4: If bit 1 is set in a power-down write, only bit 0 is stored, which clears bit 5 and bit 1 in that same write.
- R5: A power-down write that leaves bit 0 stored raises `pwroff_req` for exactly one cycle, in the cycle after the strobe.
- R6: A misc-functions write with bit 1 set raises `tc_pulse` for exactly one cycle, in the cycle after the strobe. Bit 1 is never stored and reads as zero.
- R7: A write to system-control offset 0 with bit 0 set loads that register with 0x02 and raises `sysrst_req` for one cycle. A write with bit 0 clear changes nothing.
- R8: The system-control window at a nonzero offset (select 7) reads zero. Writes to it raise no request and leave offset 0 unchanged.
- R9: Reset clears the configuration, modem, misc-functions and power-down bytes. The diagnostic byte and the system-control register keep their values across reset.
- R10: The select codes are 0 configuration, 1 diagnostic, 2 modem, 3 misc-functions, 4 power-down, 5 LED, 6 system-control offset 0 and 7 system-control other offset. The 8-bit registers read back zero-extended on the 32-bit read bus. The LED word is written and read as 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for the selected register |
| pwr_failing | input | 1 | Asynchronous power-failing indication |
| pf_irq | output | 1 | Level power-fail interrupt |
| tc_pulse | output | 1 | One-cycle floppy terminal-count pulse |
| pwroff_req | output | 1 | One-cycle power-off request |
| sysrst_req | output | 1 | One-cycle system-reset request |

## Verification
The bench builds the block with DATA_W of 32 and SYNC_STAGES raised to 3. A change on `pwr_failing` therefore takes four clock edges to reach the sticky flag, and the bench waits a latency derived from that parameter instead of a fixed count. With a 32-bit bus, the bench can write words with upper bits set and check that the narrow registers drop them, that the LED word keeps only its low half, and that the unused system-control offset reads all zeros. The reset in the middle of the run brings the retained diagnostic and system-control state within reach while the other bytes clear.

// File: rtl/auxc_pkg.sv
package auxc_pkg;
    localparam int REG_W = 8;
    localparam int LED_W = 16;

    // bit positions that software decodes
    localparam int PD_OFF_BIT  = 0;
    localparam int PD_CLR_BIT  = 1;
    localparam int PD_FAIL_BIT = 5;
    localparam int CFG_IEN_BIT = 3;
    localparam int MF_TC_BIT   = 1;
    localparam int SC_GO_BIT   = 0;
    localparam logic [REG_W-1:0] SC_STAT_VAL = 8'h02;

    typedef enum logic [2:0] {
        SEL_CFG    = 3'd0,
        SEL_DIAG   = 3'd1,
        SEL_MODEM  = 3'd2,
        SEL_MISC   = 3'd3,
        SEL_PWRDN  = 3'd4,
        SEL_LED    = 3'd5,
        SEL_SC0    = 3'd6,
        SEL_SCHI   = 3'd7
    } sel_e;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] modem;
        logic [REG_W-1:0] misc;
        logic [REG_W-1:0] pwrdn;
        logic [LED_W-1:0] led;
        logic             pf_prev;
        logic             tc;
        logic             pwroff;
        logic             sysrst;
    } ctl_state_t;

    typedef struct packed {
        logic [REG_W-1:0] diag;
        logic [REG_W-1:0] sysctl;
    } keep_state_t;
endpackage

// File: rtl/auxc_sync.sv
module auxc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/auxc_rdmux.sv
module auxc_rdmux
    import auxc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2:0]        sel,
    input  ctl_state_t        ctl,
    input  keep_state_t       keep,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (sel_e'(sel))
            SEL_CFG:   rdata[REG_W-1:0] = ctl.cfg;
            SEL_DIAG:  rdata[REG_W-1:0] = keep.diag;
            SEL_MODEM: rdata[REG_W-1:0] = ctl.modem;
            SEL_MISC:  rdata[REG_W-1:0] = ctl.misc;
            SEL_PWRDN: rdata[REG_W-1:0] = ctl.pwrdn;
            SEL_LED:   rdata[LED_W-1:0] = ctl.led;
            SEL_SC0:   rdata[REG_W-1:0] = keep.sysctl;
            SEL_SCHI:  rdata = '0;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/auxc_bank.sv
module auxc_bank
    import auxc_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              pwr_failing,
    output logic              pf_irq,
    output logic              tc_pulse,
    output logic              pwroff_req,
    output logic              sysrst_req
);
    localparam logic [REG_W-1:0] PD_WR_MASK =
        REG_W'((1 << PD_OFF_BIT) | (1 << PD_CLR_BIT));
    localparam logic [REG_W-1:0] PD_OFF_MASK  = REG_W'(1 << PD_OFF_BIT);
    localparam logic [REG_W-1:0] PD_FAIL_MASK = REG_W'(1 << PD_FAIL_BIT);
    localparam logic [REG_W-1:0] MF_TC_MASK   = REG_W'(1 << MF_TC_BIT);

    ctl_state_t  ctl_d, ctl_q;
    keep_state_t keep_d, keep_q;
    logic        pf_sync;
    logic [REG_W-1:0] pd_val;

    auxc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pwr_failing),
        .q_out (pf_sync)
    );

    always_comb begin
        ctl_d         = ctl_q;
        keep_d        = keep_q;
        ctl_d.tc      = 1'b0;
        ctl_d.pwroff  = 1'b0;
        ctl_d.sysrst  = 1'b0;
        ctl_d.pf_prev = pf_sync;
        pd_val        = (wdata[REG_W-1:0] & PD_WR_MASK) | (ctl_q.pwrdn & PD_FAIL_MASK);
        if (pd_val[PD_CLR_BIT]) pd_val = pd_val & PD_OFF_MASK;

        if (wr_en) begin
            unique case (sel_e'(sel))
                SEL_CFG:   ctl_d.cfg   = wdata[REG_W-1:0];
                SEL_DIAG:  keep_d.diag = wdata[REG_W-1:0];
                SEL_MODEM: ctl_d.modem = wdata[REG_W-1:0];
                SEL_MISC: begin
                    ctl_d.misc = wdata[REG_W-1:0] & ~MF_TC_MASK;
                    ctl_d.tc   = wdata[MF_TC_BIT];
                end
                SEL_PWRDN: begin
                    ctl_d.pwrdn  = pd_val;
                    ctl_d.pwroff = pd_val[PD_OFF_BIT];
                end
                SEL_LED:   ctl_d.led = wdata[LED_W-1:0];
                SEL_SC0: begin
                    if (wdata[SC_GO_BIT]) begin
                        keep_d.sysctl = SC_STAT_VAL;
                        ctl_d.sysrst  = 1'b1;
                    end
                end
                SEL_SCHI:  ;
                default:   ;
            endcase
        end

        // an input change re-evaluates the flag and wins over a same-cycle write
        if (pf_sync != ctl_q.pf_prev)
            ctl_d.pwrdn[PD_FAIL_BIT] = pf_sync & ctl_q.cfg[CFG_IEN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    // retained across reset on purpose
    always_ff @(posedge clk) begin
        keep_q <= keep_d;
    end

    auxc_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .sel   (sel),
        .ctl   (ctl_q),
        .keep  (keep_q),
        .rdata (rdata)
    );

    assign pf_irq     = ctl_q.pwrdn[PD_FAIL_BIT] & ctl_q.cfg[CFG_IEN_BIT];
    assign tc_pulse   = ctl_q.tc;
    assign pwroff_req = ctl_q.pwroff;
    assign sysrst_req = ctl_q.sysrst;
endmodule

// File: rtl/auxc_bank_chk.sv
module auxc_bank_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        sel,
    input logic              wr_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              pf_irq,
    input logic              tc_pulse,
    input logic              pwroff_req,
    input logic              sysrst_req
);
    a_r1_ien_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd0 && !wdata[3]) |=> !pf_irq);

    a_r3_pwrdn_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd4) |-> ((rdata & ~DATA_W'(32'h23)) == '0));

    a_r5_pwroff_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd4 && wdata[0]) |=> pwroff_req);

    a_r6_tc_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd3 && wdata[1]) |=> tc_pulse);

    a_r6_tc_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && sel == 3'd3 && wdata[1]) |=> !tc_pulse);

    a_r7_rst_req_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sysrst_req |-> $past(wr_en && sel == 3'd6 && wdata[0]));

    a_r8_high_offset_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd7) |=> !sysrst_req);

    a_r8_high_offset_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 3'd7) |-> (rdata == '0));
endmodule

bind auxc_bank auxc_bank_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel        (sel),
    .wr_en      (wr_en),
    .wdata      (wdata),
    .rdata      (rdata),
    .pf_irq     (pf_irq),
    .tc_pulse   (tc_pulse),
    .pwroff_req (pwroff_req),
    .sysrst_req (sysrst_req)
);

// File: tb/tb_auxc_bank.sv
`timescale 1ns/1ps
module tb_auxc_bank;
    localparam int DATA_W = 32;
    localparam int SYNC_STAGES = 3;
    localparam int PF_WAIT = SYNC_STAGES + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [2:0]        sel = 3'd0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              pwr_failing = 1'b0;
    logic              pf_irq, tc_pulse, pwroff_req, sysrst_req;

    typedef struct {
        string             tag;
        logic [DATA_W-1:0] exp;
        bit                is_outs;
    } item_t;

    item_t sb_q[$];
    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;

    always #10 clk = ~clk;

    auxc_bank #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pwr_failing(pwr_failing), .pf_irq(pf_irq),
        .tc_pulse(tc_pulse), .pwroff_req(pwroff_req), .sysrst_req(sysrst_req)
    );

    // monitor: pops expectations 5 ns after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [DATA_W-1:0] act;
                it  = sb_q.pop_front();
                act = it.is_outs ? DATA_W'({pf_irq, tc_pulse, pwroff_req, sysrst_req}) : rdata;
                n_tests++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] s, input logic [DATA_W-1:0] d);
        @(negedge clk);
        sel = s; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    // outputs {pf_irq, tc_pulse, pwroff_req, sysrst_req} in the current cycle
    task automatic exp_outs(input logic [3:0] e, input string tag);
        sb_q.push_back('{tag, DATA_W'(e), 1'b1});
    endtask

    task automatic exp_rd(input logic [2:0] s, input logic [DATA_W-1:0] e, input string tag);
        sel = s;
        sb_q.push_back('{tag, e, 1'b0});
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R9 reset values
        exp_outs(4'b0000, "R9 outputs idle after reset");
        exp_rd(3'd0, 32'h0, "R9 cfg cleared");
        exp_rd(3'd2, 32'h0, "R9 modem cleared");
        exp_rd(3'd3, 32'h0, "R9 misc cleared");
        exp_rd(3'd4, 32'h0, "R9 pwrdn cleared");

        // R10 byte widths and select codes
        wr(3'd0, 32'hFFFF_FF08);
        exp_rd(3'd0, 32'h08, "R10 cfg zero-extended");
        wr(3'd2, 32'h0000_005A);
        exp_rd(3'd2, 32'h5A, "R10 modem readback");
        wr(3'd5, 32'h1234_BEEF);
        exp_rd(3'd5, 32'hBEEF, "R10 led 16 bits");

        // R2 / R1 power fail
        pwr_failing = 1'b1;
        idle(PF_WAIT);
        exp_outs(4'b1000, "R1 irq with enable and fail");
        exp_rd(3'd4, 32'h20, "R2 fail flag set");
        wr(3'd0, 32'h00);
        exp_outs(4'b0000, "R1 irq drops when enable cleared");
        exp_rd(3'd4, 32'h20, "R2 flag sticky without input change");
        wr(3'd0, 32'h08);
        exp_outs(4'b1000, "R1 irq returns with enable");

        // R3 only bits 0/1 accepted, bit 5 kept
        wr(3'd4, 32'hFFFF_FFDC);
        exp_outs(4'b1000, "R3 no pwroff for bit0 clear");
        exp_rd(3'd4, 32'h20, "R3 masked write keeps fail");

        // R4 clear bit
        wr(3'd4, 32'h02);
        exp_rd(3'd4, 32'h00, "R4 clear wipes flag");
        exp_outs(4'b0000, "R4 irq gone after clear");

        // R2 evaluation with enable off, then on
        pwr_failing = 1'b0;
        idle(PF_WAIT);
        wr(3'd0, 32'h00);
        pwr_failing = 1'b1;
        idle(PF_WAIT);
        exp_rd(3'd4, 32'h00, "R2 no flag when enable off");
        wr(3'd0, 32'h08);
        pwr_failing = 1'b0;
        idle(PF_WAIT);
        pwr_failing = 1'b1;
        idle(PF_WAIT);
        exp_rd(3'd4, 32'h20, "R2 flag set on rising input");
        pwr_failing = 1'b0;
        idle(PF_WAIT);
        exp_rd(3'd4, 32'h00, "R2 flag cleared on falling input");
        pwr_failing = 1'b1;
        idle(PF_WAIT);

        // R5 power off
        wr(3'd4, 32'h01);
        exp_outs(4'b1010, "R5 pwroff pulse");
        exp_rd(3'd4, 32'h21, "R5 off bit stored with flag");
        exp_outs(4'b1000, "R5 pwroff one cycle");
        wr(3'd4, 32'h03);
        exp_outs(4'b0010, "R5 pwroff with clear");
        exp_rd(3'd4, 32'h01, "R4 clear keeps off bit");

        // R6 terminal count
        wr(3'd3, 32'hFF);
        exp_outs(4'b0100, "R6 tc pulse");
        exp_rd(3'd3, 32'hFD, "R6 tc bit not stored");
        exp_outs(4'b0000, "R6 tc one cycle");
        wr(3'd3, 32'h00);
        exp_outs(4'b0000, "R6 no pulse without bit1");

        // R7 / R8 system control
        wr(3'd6, 32'h01);
        exp_outs(4'b0001, "R7 reset request pulse");
        exp_rd(3'd6, 32'h02, "R7 status loaded");
        exp_outs(4'b0000, "R7 request one cycle");
        wr(3'd6, 32'hFFFF_FFFE);
        exp_outs(4'b0000, "R7 bit0 clear no request");
        exp_rd(3'd6, 32'h02, "R7 bit0 clear no change");
        wr(3'd7, 32'hFFFF_FFFF);
        exp_outs(4'b0000, "R8 high offset no request");
        exp_rd(3'd7, 32'h0, "R8 high offset reads zero");
        exp_rd(3'd6, 32'h02, "R8 offset 0 unchanged");

        // R9 retention across reset
        wr(3'd1, 32'hA5);
        wr(3'd0, 32'h08);
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        exp_rd(3'd1, 32'hA5, "R9 diag retained");
        exp_rd(3'd6, 32'h02, "R9 sysctl retained");
        exp_rd(3'd0, 32'h00, "R9 cfg cleared again");
        exp_rd(3'd4, 32'h00, "R9 pwrdn cleared again");
        exp_rd(3'd2, 32'h00, "R9 modem cleared again");

        idle(2);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule